// File: doc/BRIEF.md
# Self-Clocked Converter Serial Read Port

This block is the device side of a serial read port on a data converter that supplies its own serial clock. A conversion core hands new result words to the port over a valid/ready stream. The newest word is kept in an output register, and an active-low data-ready flag tells the host that an unread word is waiting. The host pulls the active-low frame-sync low to request a read. The port then drives a serial clock, divided down from the system clock, and shifts the selected register out MSB first. Once the word is complete, the port releases both the clock and the data line.

An address input chooses the source. Address low selects the control register. Address high selects the output register, or one of two calibration registers when calibration-read mode is set in the control register. Only output-register reads depend on the data-ready flag or change it. A word that arrives from the core while the output register is being read is discarded. The stream has no back-pressure: `word_ready` is always high, and every cycle with `word_valid` high either loads a word or drops it by the rules below. The address and control inputs must stay stable for the whole read.

Top module: `serial_rd_port`

## Requirements
- R1: After reset, `drdy_n` is high and `sclk_oe` and `sdata_oe` are low.
- R2: A cycle with `word_valid` high, when no output-register read is in progress, loads `word_data` into the output register and drives `drdy_n` low on the next cycle. Later words overwrite earlier unread ones, and a read returns the newest word. `word_ready` is always high.
- R3: A falling edge of `fs_n` that is allowed to start a read enables both outputs on the next cycle, with `sclk_o` high and the MSB on `sdata_o`. The clock then falls after HALF system cycles and toggles every HALF cycles. Data changes only on falling clock edges from the second one onward, so each bit is stable around its rising edge.
- R4: An output-register read transfers 24 bits when `ctrl_reg` bit 0 is 1 and 16 bits when it is 0. A 16-bit read sends output-register bits 23 down to 8.
- R5: The falling clock edge after the last rising edge disables `sclk_oe` and `sdata_oe`. For an output-register read, that same edge sets `drdy_n` high.
- R6: With `addr_sel` high, `ctrl_reg` bit 1 = 0 and `drdy_n` high, a falling edge of `fs_n` starts no transfer, and the outputs stay disabled.
- R7: A word that arrives during an output-register read is lost. It is not flagged, and a later read does not return it.
- R8: With `addr_sel` low, a read sends all 24 bits of `ctrl_reg`, whatever the state of `drdy_n`, and leaves `drdy_n` unchanged.
- R9: With `addr_sel` high and `ctrl_reg` bit 1 = 1, a read sends 24 bits of `cal1_reg` if `ctrl_reg` bit 2 is 1, or of `cal0_reg` if it is 0, and leaves `drdy_n` unchanged.
- R10: If `fs_n` goes high before a read completes, the outputs are disabled on the next cycle, `drdy_n` keeps its value, and the next read starts again from the MSB.
- R11: A read starts only on a falling edge of `fs_n`. Keeping `fs_n` low after a read has completed does not start another one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_valid | input | 1 | New conversion word present |
| word_ready | output | 1 | Always high; the port never stalls the core |
| word_data | input | W | Conversion word |
| ctrl_reg | input | W | Control register contents (bit 0 word length, bit 1 calibration-read, bit 2 calibration select) |
| cal0_reg | input | W | Calibration register 0 |
| cal1_reg | input | W | Calibration register 1 |
| addr_sel | input | 1 | 0 = control register, 1 = output/calibration |
| fs_n | input | 1 | Active-low frame-sync from the host |
| drdy_n | output | 1 | Active-low data-ready flag |
| sclk_o | output | 1 | Serial clock value |
| sclk_oe | output | 1 | Serial clock drive enable |
| sdata_o | output | 1 | Serial data value |
| sdata_oe | output | 1 | Serial data drive enable |

## Verification
The bench builds the port with W = 24, SHORT_W = 16 and HALF = 2. With HALF = 2, a full 24-bit read lasts about a hundred cycles, so overwrite, drop and abort cases fit easily in one run. Every clock cycle is compared against the reference model. A divide of two also makes any off-by-one in the placement of the edges relative to the start, the last rising edge and the release cycle show up as a mismatch in a specific cycle. Both word lengths and all three sources are read, and words are injected in the middle of output and control reads.

// File: rtl/rdp_pkg.sv
package rdp_pkg;
  // Control register field positions decoded by the port
  localparam int CTRL_LEN24_BIT  = 0;
  localparam int CTRL_CALRD_BIT  = 1;
  localparam int CTRL_CALSEL_BIT = 2;

  typedef enum logic [1:0] {
    SRC_CTRL = 2'd0,
    SRC_OUT  = 2'd1,
    SRC_CAL0 = 2'd2,
    SRC_CAL1 = 2'd3
  } rd_src_e;
endpackage

// File: rtl/rdp_clkdiv.sv
module rdp_clkdiv #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/rdp_shift.sv
module rdp_shift #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         shift,
  output logic         msb
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sr_q <= '0;
    else if (load) sr_q <= load_data;
    else if (shift) sr_q <= {sr_q[W-2:0], 1'b0};
  end

  assign msb = sr_q[W-1];
endmodule

// File: rtl/serial_rd_port.sv
module serial_rd_port
  import rdp_pkg::*;
#(
  parameter int W       = 24,
  parameter int SHORT_W = 16,
  parameter int HALF    = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         word_valid,
  output logic         word_ready,
  input  logic [W-1:0] word_data,
  input  logic [W-1:0] ctrl_reg,
  input  logic [W-1:0] cal0_reg,
  input  logic [W-1:0] cal1_reg,
  input  logic         addr_sel,
  input  logic         fs_n,
  output logic         drdy_n,
  output logic         sclk_o,
  output logic         sclk_oe,
  output logic         sdata_o,
  output logic         sdata_oe
);
  localparam int RW = $clog2(W + 1);
  localparam logic [RW-1:0] LEN_LONG  = RW'(W);
  localparam logic [RW-1:0] LEN_SHORT = RW'(SHORT_W);

  logic          fs_q;
  logic          busy_q, out_rd_q, sclk_q, drdy_q;
  logic [RW-1:0] rises_q, len_q;
  logic [W-1:0]  out_q;
  logic          tick, fs_fall, start, fin, abort, shift;
  logic          sel_out;
  rd_src_e       src;
  logic [W-1:0]  src_word;

  assign word_ready = 1'b1;
  assign fs_fall    = fs_q && !fs_n;
  assign sel_out    = addr_sel && !ctrl_reg[CTRL_CALRD_BIT];
  assign start      = !busy_q && fs_fall && !(sel_out && drdy_q);
  assign abort      = busy_q && fs_n;
  assign fin        = busy_q && tick && sclk_q && (rises_q == len_q);
  assign shift      = busy_q && tick && sclk_q && (rises_q != '0);

  always_comb begin
    if (!addr_sel) src = SRC_CTRL;
    else if (!ctrl_reg[CTRL_CALRD_BIT]) src = SRC_OUT;
    else if (ctrl_reg[CTRL_CALSEL_BIT]) src = SRC_CAL1;
    else src = SRC_CAL0;
    case (src)
      SRC_CTRL: src_word = ctrl_reg;
      SRC_OUT:  src_word = out_q;
      SRC_CAL0: src_word = cal0_reg;
      default:  src_word = cal1_reg;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) fs_q <= 1'b1;
    else fs_q <= fs_n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      out_rd_q <= 1'b0;
      sclk_q   <= 1'b1;
      rises_q  <= '0;
      len_q    <= LEN_LONG;
    end else if (abort || fin) begin
      busy_q <= 1'b0;
    end else if (start) begin
      busy_q   <= 1'b1;
      out_rd_q <= sel_out;
      sclk_q   <= 1'b1;
      rises_q  <= '0;
      len_q    <= (sel_out && !ctrl_reg[CTRL_LEN24_BIT]) ? LEN_SHORT : LEN_LONG;
    end else if (busy_q && tick) begin
      sclk_q <= !sclk_q;
      if (!sclk_q) rises_q <= rises_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q  <= '0;
      drdy_q <= 1'b1;
    end else if (word_valid && !(busy_q && out_rd_q)) begin
      out_q  <= word_data;
      drdy_q <= 1'b0;
    end else if (fin && out_rd_q && !fs_n) begin
      drdy_q <= 1'b1;
    end
  end

  rdp_clkdiv #(.HALF(HALF)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy_q), .tick(tick)
  );

  rdp_shift #(.W(W)) u_sr (
    .clk(clk), .rst_n(rst_n), .load(start), .load_data(src_word),
    .shift(shift), .msb(sdata_o)
  );

  assign drdy_n   = drdy_q;
  assign sclk_o   = sclk_q;
  assign sclk_oe  = busy_q;
  assign sdata_oe = busy_q;
endmodule

// File: rtl/serial_rd_port_chk.sv
module serial_rd_port_chk #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic         word_valid,
  input logic [W-1:0] ctrl_reg,
  input logic         addr_sel,
  input logic         fs_n,
  input logic         drdy_n,
  input logic         sclk_o,
  input logic         sclk_oe,
  input logic         sdata_oe
);
  // R2
  word_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !sclk_oe) |=> !drdy_n);

  // R3
  start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_oe) |-> (sclk_o && sdata_oe));

  // R6
  no_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(fs_n) && !sclk_oe && addr_sel && !ctrl_reg[1] && drdy_n) |=> !sclk_oe);

  // R8
  ctrl_rd_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_oe && !addr_sel && !word_valid) |=> $stable(drdy_n));

  // R10
  abort_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_oe && fs_n) |=> (!sclk_oe && !sdata_oe));
endmodule

bind serial_rd_port serial_rd_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .ctrl_reg(ctrl_reg),
  .addr_sel(addr_sel), .fs_n(fs_n), .drdy_n(drdy_n), .sclk_o(sclk_o),
  .sclk_oe(sclk_oe), .sdata_oe(sdata_oe)
);

// File: tb/sim_serial_rd_port.sv
`timescale 1ns/1ps
module sim_serial_rd_port;
  localparam int W = 24;
  localparam int SHORT_W = 16;
  localparam int HALF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic word_valid = 1'b0;
  logic [W-1:0] word_data = '0;
  logic [W-1:0] ctrl_reg = 24'h000001;
  logic [W-1:0] cal0_reg = 24'hC0FFEE;
  logic [W-1:0] cal1_reg = 24'h5A3C96;
  logic addr_sel = 1'b1;
  logic fs_n = 1'b1;
  logic word_ready, drdy_n, sclk_o, sclk_oe, sdata_o, sdata_oe;

  always #2.5 clk = ~clk;

  serial_rd_port #(.W(W), .SHORT_W(SHORT_W), .HALF(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_ready(word_ready),
    .word_data(word_data), .ctrl_reg(ctrl_reg), .cal0_reg(cal0_reg),
    .cal1_reg(cal1_reg), .addr_sel(addr_sel), .fs_n(fs_n), .drdy_n(drdy_n),
    .sclk_o(sclk_o), .sclk_oe(sclk_oe), .sdata_o(sdata_o), .sdata_oe(sdata_oe)
  );

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  bit m_busy, m_outread, m_drdy, m_fsq, m_sel;
  int m_e, m_len;
  logic [W-1:0] m_snap, m_out;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy <= 0; m_e <= 0; m_drdy <= 1; m_fsq <= 1; m_out <= '0;
      m_outread <= 0; m_len <= 24; m_snap <= '0;
    end else begin
      m_fsq <= fs_n;
      if (word_valid && !(m_busy && m_outread)) begin
        m_out <= word_data; m_drdy <= 0;
      end
      if (m_busy) begin
        if (fs_n) m_busy <= 0;
        else if (m_e + 1 == HALF * (2 * m_len + 1)) begin
          m_busy <= 0;
          if (m_outread) m_drdy <= 1;
        end else m_e <= m_e + 1;
      end else if (m_fsq && !fs_n) begin
        m_sel = addr_sel && !ctrl_reg[1];
        if (!(m_sel && m_drdy)) begin
          m_busy <= 1; m_e <= 0; m_outread <= m_sel;
          m_len <= (m_sel && !ctrl_reg[0]) ? 16 : 24;
          m_snap <= !addr_sel ? ctrl_reg : (ctrl_reg[1] ? (ctrl_reg[2] ? cal1_reg : cal0_reg) : m_out);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int idx;
      idx = (m_e < HALF) ? 0 : (m_e - HALF) / (2 * HALF);
      check(drdy_n == m_drdy, "R5 drdy_n per-cycle", drdy_n, m_drdy);
      check(sclk_oe == m_busy && sdata_oe == m_busy, "R3 output enable per-cycle", sclk_oe, m_busy);
      if (m_busy) begin
        check(sclk_o == ((m_e / HALF) % 2 == 0), "R3 sclk per-cycle", sclk_o, (m_e / HALF) % 2 == 0);
        check(sdata_o == m_snap[W-1-idx], "R4 sdata per-cycle", sdata_o, m_snap[W-1-idx]);
      end
    end
  end

  task automatic push(input logic [W-1:0] d);
    @(negedge clk); word_valid = 1; word_data = d;
    @(negedge clk); word_valid = 0;
  endtask

  // Host side: clock line with pull-up, capture data on rising edges
  task automatic read_word(input bit a, output logic [W-1:0] got, output int n);
    bit prev, line, seen;
    @(negedge clk); addr_sel = a; fs_n = 0;
    prev = 1; seen = 0; got = '0; n = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (sclk_oe) seen = 1;
      line = sclk_oe ? sclk_o : 1'b1;
      if (sclk_oe && line && !prev) begin got = {got[W-2:0], sdata_o}; n++; end
      prev = line;
      if (seen && !sclk_oe) break;
      if (!seen && i > 8) break;
    end
    repeat (4) @(negedge clk);
    check(!sclk_oe, "R11 no restart while fs_n held low", sclk_oe, 0);
    fs_n = 1;
    @(negedge clk);
  endtask

  logic [W-1:0] got;
  int n;

  initial begin
    repeat (3) @(negedge clk);
    check(drdy_n && !sclk_oe && !sdata_oe, "R1 reset state", {drdy_n, sclk_oe, sdata_oe}, 3'b100);
    rst_n = 1;
    @(negedge clk);
    check(word_ready, "R2 word_ready high", word_ready, 1);

    read_word(1, got, n);
    check(n == 0, "R6 no transfer with drdy_n high", n, 0);

    push(24'h123456);
    check(!drdy_n, "R2 drdy_n low after word", drdy_n, 0);
    push(24'hABCDEF);
    read_word(1, got, n);
    check(n == 24 && got == 24'hABCDEF, "R2 newest word read", got, 24'hABCDEF);
    check(drdy_n, "R5 drdy_n high after read", drdy_n, 1);

    ctrl_reg = 24'h000000;
    push(24'h9876F0);
    read_word(1, got, n);
    check(n == 16 && got[15:0] == 16'h9876, "R4 16-bit read", {n, got[15:0]}, {16, 16'h9876});
    ctrl_reg = 24'h000001;

    read_word(0, got, n);
    check(n == 24 && got == 24'h000001, "R8 control read with drdy_n high", got, 24'h000001);
    check(drdy_n, "R8 drdy_n unchanged", drdy_n, 1);
    push(24'h0F0F0F);
    read_word(0, got, n);
    check(n == 24 && got == 24'h000001 && !drdy_n, "R8 control read with drdy_n low", got, 24'h000001);

    ctrl_reg = 24'h000007;
    read_word(1, got, n);
    check(n == 24 && got == cal1_reg && !drdy_n, "R9 cal1 read", got, cal1_reg);
    ctrl_reg = 24'h000003;
    read_word(1, got, n);
    check(n == 24 && got == cal0_reg && !drdy_n, "R9 cal0 read", got, cal0_reg);
    ctrl_reg = 24'h000001;

    fork
      read_word(1, got, n);
      begin repeat (20) @(negedge clk); push(24'h777777); end
    join
    check(got == 24'h0F0F0F && drdy_n, "R7 mid-read word dropped", got, 24'h0F0F0F);
    read_word(1, got, n);
    check(n == 0, "R7 dropped word not flagged", n, 0);

    push(24'hA5F00F);
    @(negedge clk); addr_sel = 1; fs_n = 0;
    repeat (15) @(negedge clk);
    fs_n = 1;
    repeat (2) @(negedge clk);
    check(!sclk_oe && !drdy_n, "R10 abort keeps drdy_n", {sclk_oe, drdy_n}, 2'b00);
    read_word(1, got, n);
    check(n == 24 && got == 24'hA5F00F, "R10 restart from MSB", got, 24'hA5F00F);

    fork
      read_word(0, got, n);
      begin repeat (10) @(negedge clk); push(24'h3C3C3C); end
    join
    check(!drdy_n, "R2 word loaded during control read", drdy_n, 0);
    read_word(1, got, n);
    check(got == 24'h3C3C3C, "R2 word from control-read window", got, 24'h3C3C3C);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule